// File: doc/BRIEF.md
# Disk Sector Read Sequencer

This block runs the read of one full disk sector. It follows the platter's rotational position from two marks: an index mark, seen once per revolution, and a sector mark, seen at the start of every sector. It compares the current sector number with a sector number requested by a start command. When the requested sector comes round, it drives an external field reader through three record reads in a fixed order. For each record it passes the record type and the data word count, and it collects one checksum verdict per record.

After the third record it publishes a completion status word. That word carries a fail flag for each record, a flag for a sector mark that arrived while the read was still running, and a done flag. Bit decoding, synchronisation and checksum arithmetic stay in the field reader.

Top module: `sector_read_seq`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `sect_match` and `fr_start` are low and `status` is 5'b00000.
- R2: `start`, sampled while idle, latches `req_sector` and raises `busy` in the following cycle. `start` sampled while busy is ignored: neither the request nor the record sequence changes.
- R3: Before the first index mark the sector position is invalid and no match can occur. After an index mark, the next sector mark is sector 0. An index mark and a sector mark in the same cycle also make that mark sector 0.
- R4: Every later sector mark advances the sector number by one, wrapping from 15 to 0.
- R5: When a sector mark sampled while waiting gives a valid position equal to the latched request, `sect_match` is high for exactly the next cycle. `fr_start` for the header record is high in that same cycle.
- R6: Records are requested in the order header (`fr_rec`=0, `fr_words`=2), label (`fr_rec`=1, `fr_words`=8), data (`fr_rec`=2, `fr_words`=256). `fr_start` is a one-cycle pulse, and `fr_rec`/`fr_words` are valid with it.
- R7: After a record's `fr_start`, the next `fr_start` is issued only in the cycle after `fr_done` is sampled. `fr_done` sampled while not reading is ignored.
- R8: In the cycle after the data record's `fr_done`, `busy` is low and `status` = {done=1 (bit 4), overrun (bit 3), data fail (bit 2), label fail (bit 1), header fail (bit 0)}. A fail bit is the inverse of `fr_cksum_ok` sampled with that record's `fr_done`.
- R9: A sector mark sampled while a record read is being issued or is in progress sets the overrun bit of the coming status, and the read runs to completion.
- R10: `status` keeps its value from one completion to the next and is unaffected by marks, starts or `fr_done` in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| index_mark | input | 1 | One-cycle index mark pulse |
| sector_mark | input | 1 | One-cycle sector mark pulse |
| req_sector | input | 4 | Requested sector number, sampled with start |
| start | input | 1 | Start command |
| fr_done | input | 1 | Field reader finished current record, sync dropped |
| fr_cksum_ok | input | 1 | Checksum verdict, valid with fr_done |
| sect_match | output | 1 | One-cycle pulse on reaching the requested sector |
| fr_start | output | 1 | One-cycle command to read a record |
| fr_rec | output | 2 | Record selector: 0 header, 1 label, 2 data |
| fr_words | output | 9 | Data word count of the selected record |
| busy | output | 1 | Read request pending or in progress |
| status | output | 5 | Completion status word |

## Verification
A wrong sector count appears as a `sect_match` on the wrong mark, or on no mark at all. It shows in the cycle after that mark, and it persists until the next index mark realigns the count. A corrupted record pointer shows as a wrong `fr_rec` or `fr_words` at the next `fr_start`. A lost or duplicated phase shows as a missing or extra `fr_start` or as `busy` dropping early. A status accumulation fault stays hidden until the completion cycle, when the published word differs in the affected bit.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        REC_HDR = 2'd0,
        REC_LBL = 2'd1,
        REC_DAT = 2'd2
    } rec_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_ISSUE,
        S_READ
    } seq_state_e;

    typedef struct packed {
        logic done;
        logic overrun;
        logic dat_fail;
        logic lbl_fail;
        logic hdr_fail;
    } status_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/srs_sector_tracker.sv
module srs_sector_tracker #(
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              index_mark,
    input  logic              sector_mark,
    output logic              mark_valid,
    output logic [SECT_W-1:0] mark_sector
);
    logic              armed_q;
    logic              valid_q;
    logic [SECT_W-1:0] cur_q;
    logic              mark_zero;

    // A mark is sector zero if an index mark armed it earlier or arrives with it
    assign mark_zero   = sector_mark & (armed_q | index_mark);
    assign mark_valid  = mark_zero | valid_q;
    assign mark_sector = mark_zero ? '0 : cur_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            valid_q <= 1'b0;
            cur_q   <= '0;
        end else if (sector_mark) begin
            armed_q <= 1'b0;
            valid_q <= mark_valid;
            cur_q   <= mark_sector;
        end else if (index_mark) begin
            armed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/srs_record_seq.sv
module srs_record_seq
    import srs_pkg::*;
#(
    parameter int SECT_W    = 4,
    parameter int WORDS_W   = 9,
    parameter int HDR_WORDS = 2,
    parameter int LBL_WORDS = 8,
    parameter int DAT_WORDS = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [SECT_W-1:0]  req_sector,
    input  logic               sector_mark,
    input  logic               mark_valid,
    input  logic [SECT_W-1:0]  mark_sector,
    input  logic               fr_done,
    output logic               sect_match,
    output logic               fr_start,
    output rec_e               fr_rec,
    output logic [WORDS_W-1:0] fr_words,
    output logic               busy,
    output logic               accept,
    output logic               rec_done,
    output logic               finish,
    output logic               overrun_evt
);
    seq_state_e        state_q;
    logic [SECT_W-1:0] req_q;
    rec_e              rec_q;
    logic              match_q;
    logic              hit;

    assign hit         = sector_mark & mark_valid & (mark_sector == req_q);
    assign accept      = (state_q == S_IDLE) & start;
    assign rec_done    = (state_q == S_READ) & fr_done;
    assign finish      = rec_done & (rec_q == REC_DAT);
    assign overrun_evt = sector_mark & ((state_q == S_ISSUE) | (state_q == S_READ));
    assign fr_start    = (state_q == S_ISSUE);
    assign busy        = (state_q != S_IDLE);
    assign sect_match  = match_q;
    assign fr_rec      = rec_q;

    always_comb begin
        unique case (rec_q)
            REC_HDR: fr_words = WORDS_W'(HDR_WORDS);
            REC_LBL: fr_words = WORDS_W'(LBL_WORDS);
            default: fr_words = WORDS_W'(DAT_WORDS);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            req_q   <= '0;
            rec_q   <= REC_HDR;
            match_q <= 1'b0;
        end else begin
            match_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        req_q   <= req_sector;
                        state_q <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (hit) begin
                        match_q <= 1'b1;
                        rec_q   <= REC_HDR;
                        state_q <= S_ISSUE;
                    end
                end
                S_ISSUE: state_q <= S_READ;
                S_READ: begin
                    if (fr_done) begin
                        if (rec_q == REC_DAT) begin
                            state_q <= S_IDLE;
                        end else begin
                            rec_q   <= (rec_q == REC_HDR) ? REC_LBL : REC_DAT;
                            state_q <= S_ISSUE;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srs_status_reg.sv
module srs_status_reg
    import srs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  logic    rec_done,
    input  rec_e    rec,
    input  logic    cksum_ok,
    input  logic    overrun_evt,
    input  logic    finish,
    output status_t status
);
    status_t work_q;
    status_t work_d;
    status_t status_q;

    always_comb begin
        work_d = work_q;
        if (overrun_evt) work_d.overrun = 1'b1;
        if (rec_done && !cksum_ok) begin
            unique case (rec)
                REC_HDR: work_d.hdr_fail = 1'b1;
                REC_LBL: work_d.lbl_fail = 1'b1;
                default: work_d.dat_fail = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q   <= '0;
            status_q <= '0;
        end else begin
            work_q <= accept ? '0 : work_d;
            if (finish) begin
                status_q      <= work_d;
                status_q.done <= 1'b1;
            end
        end
    end

    assign status = status_q;

endmodule

// File: rtl/sector_read_seq.sv
module sector_read_seq
    import srs_pkg::*;
#(
    parameter int SECT_W    = 4,
    parameter int HDR_WORDS = 2,
    parameter int LBL_WORDS = 8,
    parameter int DAT_WORDS = 256,
    localparam int WORDS_W  = $clog2(max3(HDR_WORDS, LBL_WORDS, DAT_WORDS) + 1),
    localparam int STAT_W   = $bits(status_t)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               index_mark,
    input  logic               sector_mark,
    input  logic [SECT_W-1:0]  req_sector,
    input  logic               start,
    input  logic               fr_done,
    input  logic               fr_cksum_ok,
    output logic               sect_match,
    output logic               fr_start,
    output logic [1:0]         fr_rec,
    output logic [WORDS_W-1:0] fr_words,
    output logic               busy,
    output logic [STAT_W-1:0]  status
);
    logic              mark_valid;
    logic [SECT_W-1:0] mark_sector;
    logic              accept;
    logic              rec_done;
    logic              finish;
    logic              overrun_evt;
    rec_e              rec;
    status_t           stat;

    srs_sector_tracker #(.SECT_W(SECT_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .index_mark  (index_mark),
        .sector_mark (sector_mark),
        .mark_valid  (mark_valid),
        .mark_sector (mark_sector)
    );

    srs_record_seq #(
        .SECT_W    (SECT_W),
        .WORDS_W   (WORDS_W),
        .HDR_WORDS (HDR_WORDS),
        .LBL_WORDS (LBL_WORDS),
        .DAT_WORDS (DAT_WORDS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .req_sector  (req_sector),
        .sector_mark (sector_mark),
        .mark_valid  (mark_valid),
        .mark_sector (mark_sector),
        .fr_done     (fr_done),
        .sect_match  (sect_match),
        .fr_start    (fr_start),
        .fr_rec      (rec),
        .fr_words    (fr_words),
        .busy        (busy),
        .accept      (accept),
        .rec_done    (rec_done),
        .finish      (finish),
        .overrun_evt (overrun_evt)
    );

    srs_status_reg u_stat (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .rec_done    (rec_done),
        .rec         (rec),
        .cksum_ok    (fr_cksum_ok),
        .overrun_evt (overrun_evt),
        .finish      (finish),
        .status      (stat)
    );

    assign fr_rec = rec;
    assign status = stat;

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
    parameter int HDR_WORDS = 2,
    parameter int LBL_WORDS = 8,
    parameter int DAT_WORDS = 256,
    parameter int WORDS_W   = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               index_mark,
    input logic               fr_done,
    input logic               sect_match,
    input logic               fr_start,
    input logic [1:0]         fr_rec,
    input logic [WORDS_W-1:0] fr_words,
    input logic               busy
);
    logic       seen_index;
    logic       pending;
    logic [1:0] rec_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_index <= 1'b0;
            pending    <= 1'b0;
            rec_exp    <= 2'd0;
        end else begin
            if (index_mark) seen_index <= 1'b1;
            if (fr_start) begin
                pending <= 1'b1;
                rec_exp <= (rec_exp == 2'd2) ? 2'd0 : rec_exp + 2'd1;
            end else if (fr_done) begin
                pending <= 1'b0;
            end
        end
    end

    AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sect_match |=> !sect_match); // R5
    AST_MATCH_NEEDS_INDEX: assert property (@(posedge clk) disable iff (rst)
        sect_match |-> seen_index); // R3
    AST_MATCH_STARTS_HDR: assert property (@(posedge clk) disable iff (rst)
        sect_match |-> (fr_start && fr_rec == 2'd0 && busy)); // R5
    AST_REC_ORDER: assert property (@(posedge clk) disable iff (rst)
        fr_start |-> (fr_rec == rec_exp)); // R6
    AST_REC_WORDS: assert property (@(posedge clk) disable iff (rst)
        fr_start |-> (fr_words == ((fr_rec == 2'd0) ? WORDS_W'(HDR_WORDS) :
                                   (fr_rec == 2'd1) ? WORDS_W'(LBL_WORDS) :
                                                      WORDS_W'(DAT_WORDS)))); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        fr_start |-> !pending); // R7
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        fr_start |=> !fr_start); // R6

endmodule

bind sector_read_seq srs_checker #(
    .HDR_WORDS (HDR_WORDS),
    .LBL_WORDS (LBL_WORDS),
    .DAT_WORDS (DAT_WORDS),
    .WORDS_W   (WORDS_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .index_mark (index_mark),
    .fr_done    (fr_done),
    .sect_match (sect_match),
    .fr_start   (fr_start),
    .fr_rec     (fr_rec),
    .fr_words   (fr_words),
    .busy       (busy)
);

// File: tb/tb_sector_read_seq.sv
module tb_sector_read_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       index_mark = 1'b0;
    logic       sector_mark = 1'b0;
    logic [3:0] req_sector = '0;
    logic       start = 1'b0;
    logic       fr_done = 1'b0;
    logic       fr_cksum_ok = 1'b0;
    logic       sect_match;
    logic       fr_start;
    logic [1:0] fr_rec;
    logic [8:0] fr_words;
    logic       busy;
    logic [4:0] status;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    // bench model
    bit         m_armed = 0;
    bit         m_valid = 0;
    int         m_pos = 0;
    bit         waiting = 0;
    bit         in_read = 0;
    bit         m_ovr = 0;
    logic [3:0] m_req = '0;
    logic [4:0] m_status = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_read_seq dut (
        .clk(clk), .rst(rst), .index_mark(index_mark), .sector_mark(sector_mark),
        .req_sector(req_sector), .start(start), .fr_done(fr_done),
        .fr_cksum_ok(fr_cksum_ok), .sect_match(sect_match), .fr_start(fr_start),
        .fr_rec(fr_rec), .fr_words(fr_words), .busy(busy), .status(status)
    );

    function automatic int words_of(input int r);
        return (r == 0) ? 2 : (r == 1) ? 8 : 256;
    endfunction

    function automatic logic [4:0] exp_status(input logic [2:0] ok, input bit ovr);
        return {1'b1, ovr, ~ok[2], ~ok[1], ~ok[0]};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic pulse_index();
        index_mark = 1'b1;
        @(negedge clk);
        index_mark = 1'b0;
        m_armed = 1;
    endtask

    task automatic pulse_sector(input string tag, output bit hit);
        bit exp;
        sector_mark = 1'b1;
        @(negedge clk);
        sector_mark = 1'b0;
        if (m_armed) begin
            m_pos = 0; m_valid = 1; m_armed = 0;
        end else if (m_valid) begin
            m_pos = (m_pos + 1) % 16;
        end
        if (in_read) m_ovr = 1;
        exp = waiting && m_valid && (m_pos == int'(m_req));
        check(tag, int'(sect_match), int'(exp));
        hit = exp;
        if (exp) waiting = 0;
    endtask

    task automatic do_start(input logic [3:0] r);
        start = 1'b1;
        req_sector = r;
        @(negedge clk);
        start = 1'b0;
        m_req = r;
        waiting = 1;
        check("R2 busy after start", int'(busy), 1);
    endtask

    task automatic seek();
        bit hit = 0;
        int n = 0;
        while (!hit && n < 40) begin
            if ((!m_valid && !m_armed) || ($urandom % 10 == 0)) pulse_index();
            pulse_sector("R4 match on counted mark", hit);
            if (!hit) repeat ($urandom % 3) idle_cycle();
            n++;
        end
    endtask

    task automatic do_records(input logic [2:0] ok, input bit inj_ovr, input bit inj_start);
        bit h;
        in_read = 1;
        m_ovr = 0;
        for (int r = 0; r < 3; r++) begin
            int lat;
            check("R7 fr_start issued", int'(fr_start), 1);
            check("R6 record order", int'(fr_rec), r);
            check("R6 record words", int'(fr_words), words_of(r));
            lat = 1 + int'($urandom % 4);
            for (int k = 0; k < lat; k++) begin
                if (inj_ovr && r == 1 && k == 0) begin
                    pulse_sector("R9 no match while reading", h);
                end else if (inj_start && r == 0 && k == 0) begin
                    start = 1'b1;
                    req_sector = m_req + 4'd5;
                    @(negedge clk);
                    start = 1'b0;
                    check("R2 start ignored while busy", int'(busy), 1);
                end else begin
                    @(negedge clk);
                    check("R7 no fr_start before done", int'(fr_start), 0);
                end
            end
            fr_done = 1'b1;
            fr_cksum_ok = ok[r];
            @(negedge clk);
            fr_done = 1'b0;
            fr_cksum_ok = 1'b0;
        end
        in_read = 0;
        m_status = exp_status(ok, m_ovr);
        check("R8 busy low at end", int'(busy), 0);
        check("R8 status word", int'(status), int'(m_status));
        if (inj_ovr) check("R9 overrun bit", int'(status[3]), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit h;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 status reset", int'(status), 0);
        check("R1 busy reset", int'(busy), 0);
        check("R1 match reset", int'(sect_match), 0);
        check("R1 fr_start reset", int'(fr_start), 0);

        // no match before any index mark, request sector 0
        do_start(4'd0);
        for (int i = 0; i < 3; i++) pulse_sector("R3 no match before index", h);
        pulse_index();
        pulse_sector("R3 first mark after index is sector 0", h);
        check("R3 match at sector 0", int'(h), 1);
        do_records(3'b111, 0, 0);

        // fr_done and marks while idle leave status alone
        fr_done = 1'b1; fr_cksum_ok = 1'b0;
        @(negedge clk);
        fr_done = 1'b0;
        check("R7 fr_done ignored when idle", int'(fr_start), 0);
        pulse_sector("R10 mark while idle", h);
        check("R10 status held", int'(status), int'(m_status));

        // index and sector mark in the same cycle, request sector 0
        do_start(4'd0);
        index_mark = 1'b1; m_armed = 1;
        pulse_sector("R3 simultaneous index and mark", h);
        index_mark = 1'b0;
        check("R3 simultaneous gives sector 0", int'(h), 1);
        do_records(3'b010, 0, 0);

        // wrap: request 15 then 0 without index
        do_start(4'd15);
        while (waiting) pulse_sector("R4 counting to 15", h);
        do_records(3'b101, 1, 0);
        do_start(4'd0);
        while (waiting) pulse_sector("R4 wrap 15 to 0", h);
        check("R4 wrapped position", m_pos, 0);
        do_records(3'b000, 0, 1);

        // constrained random reads
        for (int n = 0; n < 20; n++) begin
            logic [3:0] r;
            r = 4'($urandom);
            do_start(r);
            seek();
            do_records(3'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);
            repeat ($urandom % 3) idle_cycle();
            check("R10 status stable between reads", int'(status), int'(m_status));
        end

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule